// File: doc/BRIEF.md
# FIFO Interrupt Status and Enable Unit

This unit raises the interrupt for one serial channel whose data flows through a receive FIFO and a transmit FIFO. It watches the FIFO fill level, the free space, both empty flags and a bus-error flag. It compares the fill level and the free space against programmable thresholds, and it runs a receive-idle timer. From these it builds one status word that a handler can fetch in a single read, and it drives a single registered interrupt line.

Interrupt enables are set only: writing a one sets the matching enable, and writing a zero changes nothing. Enables are cleared through a separate write-one-to-clear input. Writing a one to the timeout enable also restarts the idle timer, whether or not that enable was already set. A small register port with one cycle of read latency gives access to the status word (word address 0) and the enable word (word address 1).

Top module: `fifo_irq_unit`

## Requirements
- R1: A write to word address 1 sets every enable whose data bit is 1: bit 0 is the receive-threshold enable, bit 1 the transmit-threshold enable and bit 4 the timeout enable. A data bit of 0 leaves its enable unchanged. Reading address 1 returns the enables at bits 0, 1 and 4, with all other bits zero.
- R2: After reset all enables are 0, the interrupt output is 0 and the read data is 0.
- R3: Status bit 0 is 1 exactly when the receive count is greater than or equal to the receive threshold and the receive-threshold enable is set. Status bit 1 is 1 exactly when the transmit free space is greater than or equal to the transmit threshold and the transmit-threshold enable is set.
- R4: While the timeout enable is set and the receive FIFO is not empty, the timeout flag becomes 1 at the limit-th consecutive clock edge with no push and no pop, counted from the last reload. A push or a pop reloads the count. Once set, the flag stays set through later pushes and pops.
- R5: Status bit 4 is the timeout flag gated by the timeout enable. The flag clears when the receive FIFO is empty, and it is held clear while the timeout enable is 0.
- R6: Every write of 1 to enable bit 4 clears the timeout flag and restarts the count, even when that enable is already set.
- R7: Status bit 7 follows the bus-error flag and needs no enable. Status bits 8 and 9 follow the receive-empty and transmit-empty flags.
- R8: Status bits 23:16 carry the receive count and bits 31:24 carry the transmit free space. Bits 6:5, 3:2 and 15:10 read 0.
- R9: The interrupt output equals, one clock later, the OR of status bits 0, 1, 4 and 7.
- R10: A 1 on bit 0, 1 or 4 of the clear input clears the matching enable. If a bus write sets the same enable in the same cycle, the set wins.
- R11: Read data appears on the clock edge after the read request. Writes to address 0 have no effect. Reads from any address other than 0 or 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | CNT_W | Receive FIFO fill level |
| tx_space | input | CNT_W | Transmit FIFO free entries |
| rx_empty | input | 1 | Receive FIFO empty |
| tx_empty | input | 1 | Transmit FIFO empty |
| bus_err | input | 1 | Bus error flag |
| rx_push | input | 1 | A word entered the receive FIFO |
| rx_pop | input | 1 | A word left the receive FIFO |
| rx_thresh | input | CNT_W | Receive threshold level |
| tx_thresh | input | CNT_W | Transmit threshold level |
| tmo_limit | input | TMO_W | Idle edges before timeout |
| en_clr | input | 8 | Write-one-to-clear mask for the enables |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the push and pop strobes, the FIFO flags and the clear mask come from synchronous logic and stay stable around the clock edge. They also assume that the receive-empty flag agrees with the fill level, because the timer uses only the flag. The bench drives every input at the falling edge and keeps the empty flag consistent with the count it presents. It holds the timeout limit large during the table walk so that no timeout fires there, and it lowers the limit only for the directed timer tests.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int N_EN     = 3;
  localparam int IDX_RXTH = 0;
  localparam int IDX_TXTH = 1;
  localparam int IDX_TMO  = 2;

  localparam int ST_RXTH  = 0;
  localparam int ST_TXTH  = 1;
  localparam int ST_TMO   = 4;
  localparam int ST_BERR  = 7;
  localparam int ST_RXE   = 8;
  localparam int ST_TXE   = 9;
  localparam int RXCNT_LO = 16;
  localparam int TXSP_LO  = 24;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_ENABLE = 1;

  // word bit position of each enable (shared by the enable and status words)
  function automatic int en_bit(input int idx);
    case (idx)
      IDX_RXTH: return ST_RXTH;
      IDX_TXTH: return ST_TXTH;
      default:  return ST_TMO;
    endcase
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] en
);
  logic [N-1:0] set_eff;
  assign set_eff = wr_en ? set_vec : '0;

  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else     en <= (en & ~clr_vec) | set_eff;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
      (wr_en && set_vec[i]) |=> en[i]);
    assert_zero_keeps_R1: assert property (@(posedge clk) disable iff (rst)
      (!(wr_en && set_vec[i]) && !clr_vec[i]) |=> $stable(en[i]));
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[i] && !(wr_en && set_vec[i])) |=> !en[i]);
  end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             restart,
  input  logic             rx_empty,
  input  logic             rx_move,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;
  logic [TMO_W:0]   cnt_next;
  assign cnt_next = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart || !enable || rx_empty) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (rx_move) begin
      cnt <= '0;
    end else if (!expired) begin
      if (cnt_next >= {1'b0, limit}) expired <= 1'b1;
      else                           cnt     <= cnt_next[TMO_W-1:0];
    end
  end

  assert_empty_clears_R5: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> !expired);
  assert_disabled_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !expired);
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> !expired);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (expired && enable && !rx_empty && !restart) |=> expired);
endmodule

// File: rtl/irq_status_pack.sv
module irq_status_pack
  import fifo_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_space,
  input  logic [CNT_W-1:0] rx_thresh,
  input  logic [CNT_W-1:0] tx_thresh,
  input  logic             rx_empty,
  input  logic             tx_empty,
  input  logic             bus_err,
  input  logic             tmo_flag,
  input  logic [N_EN-1:0]  en,
  output logic [DATA_W-1:0] status,
  output logic             irq_any
);
  always_comb begin
    status                  = '0;
    status[ST_RXTH]         = en[IDX_RXTH] && (rx_count >= rx_thresh);
    status[ST_TXTH]         = en[IDX_TXTH] && (tx_space >= tx_thresh);
    status[ST_TMO]          = en[IDX_TMO] && tmo_flag;
    status[ST_BERR]         = bus_err;
    status[ST_RXE]          = rx_empty;
    status[ST_TXE]          = tx_empty;
    status[RXCNT_LO +: 8]   = 8'(rx_count);
    status[TXSP_LO +: 8]    = 8'(tx_space);
  end

  assign irq_any = status[ST_RXTH] | status[ST_TXTH] | status[ST_TMO] | status[ST_BERR];
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fifo_irq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TMO_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_space,
  input  logic              rx_empty,
  input  logic              tx_empty,
  input  logic              bus_err,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic [CNT_W-1:0]  rx_thresh,
  input  logic [CNT_W-1:0]  tx_thresh,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [7:0]        en_clr,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic [N_EN-1:0]   en, set_vec, clr_vec;
  logic [DATA_W-1:0] status, en_word;
  logic              wr_en, tmo_flag, irq_any;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata, en_clr};
  assign wr_en = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADDR_ENABLE));

  always_comb begin
    en_word = '0;
    for (int i = 0; i < N_EN; i++) begin
      set_vec[i]          = bus_wdata[en_bit(i)];
      clr_vec[i]          = en_clr[en_bit(i)];
      en_word[en_bit(i)]  = en[i];
    end
  end

  irq_enable_reg #(.N(N_EN)) u_en (
    .clk(clk), .rst(rst), .wr_en(wr_en), .set_vec(set_vec),
    .clr_vec(clr_vec), .en(en)
  );

  rx_idle_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst(rst), .enable(en[IDX_TMO]),
    .restart(wr_en && set_vec[IDX_TMO]), .rx_empty(rx_empty),
    .rx_move(rx_push | rx_pop), .limit(tmo_limit), .expired(tmo_flag)
  );

  irq_status_pack #(.CNT_W(CNT_W)) u_st (
    .rx_count(rx_count), .tx_space(tx_space), .rx_thresh(rx_thresh),
    .tx_thresh(tx_thresh), .rx_empty(rx_empty), .tx_empty(tx_empty),
    .bus_err(bus_err), .tmo_flag(tmo_flag), .en(en),
    .status(status), .irq_any(irq_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= irq_any;
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          ADDR_W'(ADDR_STATUS): bus_rdata <= status;
          ADDR_W'(ADDR_ENABLE): bus_rdata <= en_word;
          default:              bus_rdata <= '0;
        endcase
      end
    end
  end

  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(irq_any)));
  assert_berr_irq_R7: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> irq);
  assert_tmo_gated_R5: assert property (@(posedge clk) disable iff (rst)
    status[ST_TMO] |-> tmo_flag);
endmodule

// File: tb/sim_fifo_irq_unit.sv
`timescale 1ns/1ps
module sim_fifo_irq_unit;
  logic        clk = 0, rst = 1;
  logic [7:0]  rx_count = 0, tx_space = 16, rx_thresh = 4, tx_thresh = 8;
  logic        rx_empty = 1, tx_empty = 1, bus_err = 0, rx_push = 0, rx_pop = 0;
  logic [15:0] tmo_limit = 5;
  logic [7:0]  en_clr = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, rv;
  logic        irq;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  fifo_irq_unit u0 (
    .clk(clk), .rst(rst), .rx_count(rx_count), .tx_space(tx_space),
    .rx_empty(rx_empty), .tx_empty(tx_empty), .bus_err(bus_err),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_thresh(rx_thresh),
    .tx_thresh(tx_thresh), .tmo_limit(tmo_limit), .en_clr(en_clr),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {en[2:0], rx_count, tx_space, rx_thresh, tx_thresh, bus_err, rx_empty, tx_empty}
  localparam logic [37:0] VEC [8] = '{
    {3'b011, 8'd5,  8'd10, 8'd5,  8'd11, 1'b0, 1'b0, 1'b0},
    {3'b011, 8'd4,  8'd11, 8'd5,  8'd11, 1'b0, 1'b0, 1'b0},
    {3'b000, 8'd9,  8'd30, 8'd2,  8'd3,  1'b0, 1'b0, 1'b0},
    {3'b000, 8'd0,  8'd0,  8'd1,  8'd1,  1'b1, 1'b1, 1'b1},
    {3'b001, 8'd0,  8'd7,  8'd0,  8'd200,1'b0, 1'b1, 1'b0},
    {3'b110, 8'd255,8'd255,8'd255,8'd254,1'b0, 1'b0, 1'b0},
    {3'b111, 8'd3,  8'd1,  8'd200,8'd2,  1'b1, 1'b0, 1'b0},
    {3'b010, 8'd1,  8'd0,  8'd0,  8'd0,  1'b0, 1'b0, 1'b1}
  };

  function automatic logic [31:0] model(input logic [7:0] rc, ts, rt, tt,
      input logic be, re, te, input logic [2:0] e, input logic fl);
    logic [31:0] m = 0;
    m[0] = e[0] && (rc >= rt);
    m[1] = e[1] && (ts >= tt);
    m[4] = e[2] && fl;
    m[7] = be; m[8] = re; m[9] = te;
    m[23:16] = rc; m[31:24] = ts;
    return m;
  endfunction

  function automatic logic [31:0] en_model(input logic [2:0] e);
    return {27'd0, e[2], 2'b00, e[1], e[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic clr_all();
    en_clr = 8'h13;
    @(negedge clk);
    en_clr = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R2: reset state
    chk("R2 irq after reset", {31'd0, irq}, 0);
    chk("R2 rdata after reset", bus_rdata, 0);
    rd(1, rv); chk("R2 enables after reset", rv, 0);
    rd(0, rv); chk("R7 R8 status after reset", rv,
                   model(0, 16, 4, 8, 0, 1, 1, 3'b000, 0));

    // table walk: R3 R7 R8 R9 R1
    tmo_limit = 16'd1000;
    for (int i = 0; i < 8; i++) begin
      logic [37:0] v = VEC[i];
      {rx_count, tx_space, rx_thresh, tx_thresh, bus_err, rx_empty, tx_empty} = v[34:0];
      clr_all();
      wr(1, en_model(v[37:35]));
      rd(0, rv);
      chk("R3 R7 R8 status vector", rv,
          model(rx_count, tx_space, rx_thresh, tx_thresh, bus_err, rx_empty,
                tx_empty, v[37:35], 0));
      chk("R9 irq vector", {31'd0, irq}, {31'd0, |{rv[0], rv[1], rv[4], rv[7]}});
      rd(1, rv);
      chk("R1 enable readback", rv, en_model(v[37:35]));
    end

    // R10 and R11
    clr_all();
    rd(1, rv); chk("R10 clear input", rv, 0);
    bus_err = 0; rx_empty = 0; tx_empty = 0; rx_count = 1; rx_thresh = 200;
    tx_space = 16; tx_thresh = 255; tmo_limit = 5;
    wr(0, 32'hFFFF_FFFF);
    rd(1, rv); chk("R11 write to status ignored", rv, 0);
    rd(2, rv); chk("R11 unmapped read", rv, 0);

    // R4: timeout after limit idle edges
    wr(1, 32'h10);
    repeat (4) @(negedge clk);
    rd(0, rv); chk("R4 not yet expired", (rv >> 4) & 1, 0);
    rd(0, rv); chk("R4 expired at limit", (rv >> 4) & 1, 1);
    chk("R9 irq from timeout", {31'd0, irq}, 1);

    // R6: rewrite restarts even while set
    wr(1, 32'h10);
    rd(0, rv); chk("R6 restart clears flag", (rv >> 4) & 1, 0);
    rd(1, rv); chk("R1 enable kept on rewrite", rv, 32'h10);

    // R4: push reloads the count
    repeat (2) @(negedge clk);
    rx_push = 1; @(negedge clk); rx_push = 0;
    repeat (4) @(negedge clk);
    rd(0, rv); chk("R4 push reloads", (rv >> 4) & 1, 0);
    rd(0, rv); chk("R4 expires after reload", (rv >> 4) & 1, 1);
    rx_pop = 1; @(negedge clk); rx_pop = 0;
    rd(0, rv); chk("R4 flag sticky through pop", (rv >> 4) & 1, 1);

    // R5: empty clears flag
    rx_empty = 1; rx_count = 0;
    @(negedge clk);
    rd(0, rv); chk("R5 empty clears timeout", (rv >> 4) & 1, 0);

    // R1: zero write has no effect
    wr(1, 32'h0);
    rd(1, rv); chk("R1 zero write keeps enables", rv, 32'h10);

    // R5: timer held while disabled
    en_clr = 8'h10; @(negedge clk); en_clr = 0;
    rx_empty = 0; rx_count = 1;
    repeat (10) @(negedge clk);
    wr(1, 32'h10);
    rd(0, rv); chk("R5 no timeout while disabled", (rv >> 4) & 1, 0);

    // R10: set beats clear in same cycle
    clr_all();
    en_clr = 8'h01; bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 32'h1;
    @(negedge clk);
    en_clr = 0; bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    rd(1, rv); chk("R10 set wins over clear", rv, 32'h1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule